// File: doc/BRIEF.md
# Result Latency Bypass Scoreboard

This block decides whether an instruction waiting to issue must hold back because one of its source registers is still being computed by an earlier instruction. The block keeps one timing entry for every register in an integer file and a floating-point file. When a result-producing instruction issues, its destination entry restarts at age zero and records the producer's class. A consumer presents its class and its source registers, and the block returns a single stall indication.

The wait time is not a fixed property of the producer. It depends on the pair of producer class and consumer class, and on which source slot is involved. Several forwarding paths are shorter than the nominal latency. One of them, into the data operand of an integer store, takes zero cycles. Load latency is a fixed base of one cycle plus the parameter `MEM_LAT`.

A producer issuing in the same cycle as a consumer query is visible to that query at age zero. Register index 31 of each file is hardwired and never waits.

Top module: `lat_scoreboard`

## Requirements
- R1: After reset no register is pending, so a valid consumer with any sources sees stall_o low.
- R2: Producer class codes are 0 add/logic, 1 shift/cmov, 2 compare, 3 mul32, 4 mul64, 5 load, 6 fp op, 7 div single and 8 div double. Their nominal latencies are 2, 2, 2, 21, 23, 1+MEM_LAT, 6, 34 and 63. A consumer presented k cycles after the producer issues (k=0 is the same cycle) is blocked on that source while k is below the latency that applies.
- R3: An add/logic result reaches consumers of class 9 (branch) and of classes 0 to 4 after 1 cycle.
- R4: A compare result reaches a branch (class 9) after 1 cycle. Every other consumer of a compare waits the nominal 2.
- R5: For an integer store consumer (class 10), source slot 1 is the data operand. An add/logic, shift or compare result feeding that slot waits 0 cycles, including a producer issuing in the same cycle.
- R6: A mul32 or mul64 result feeding the data slot of an integer store waits 20 or 22 cycles.
- R7: An fp op result consumed by another fp op (class 6) waits 4 cycles. Other consumers, such as an fp store (class 11), wait 6.
- R8: The address operand of a store (source slot 0) gets no shortening and waits the nominal latency.
- R9: Registers are 6 bits wide: bit 5 selects the file and bits 4:0 the index. Index 31 in either file never blocks, and an issue that targets it changes nothing.
- R10: An issue of class 9, 10, 11 or 12 writes no result and leaves the destination entry unchanged.
- R11: A newer producer to the same register replaces the older one's class and issue time.
- R12: stall_o is high only when cons_valid_i is high and at least one source is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | A producer issues this cycle |
| iss_class_i | input | 4 | Class code of the issuing instruction |
| iss_dst_i | input | 6 | Destination register {file, index} |
| cons_valid_i | input | 1 | A consumer query is present |
| cons_class_i | input | 4 | Class code of the consumer |
| cons_src_i | input | NUM_SRC x 6 | Source registers; slot 1 is store data |
| stall_o | output | 1 | Consumer must wait |

## Verification
stall_o is combinational. It answers in the same cycle as the query and already counts a producer issuing in that cycle as age zero. A consumer presented k clock edges after its producer issued is therefore due to stall exactly while k is below the pair latency. The bench drives every input at the falling edge and samples stall_o 1 ns later. Its reference model advances one cycle per rising edge, so each comparison uses the age the design holds in that cycle. Directed sweeps step k from 0 to just past each pair's latency to catch both edges of every window.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_IADD   = 4'd0,
    CLS_SHIFT  = 4'd1,
    CLS_ICMP   = 4'd2,
    CLS_IMUL32 = 4'd3,
    CLS_IMUL64 = 4'd4,
    CLS_LOAD   = 4'd5,
    CLS_FPOP   = 4'd6,
    CLS_FDIV32 = 4'd7,
    CLS_FDIV64 = 4'd8,
    CLS_BRANCH = 4'd9,
    CLS_ISTORE = 4'd10,
    CLS_FSTORE = 4'd11,
    CLS_MISC   = 4'd12
  } op_class_e;

  function automatic logic writes_result(op_class_e c);
    return c inside {CLS_IADD, CLS_SHIFT, CLS_ICMP, CLS_IMUL32, CLS_IMUL64,
                     CLS_LOAD, CLS_FPOP, CLS_FDIV32, CLS_FDIV64};
  endfunction
endpackage

// File: rtl/sb_lat_sel.sv
module sb_lat_sel import sb_pkg::*; #(
  parameter int AGE_W   = 6,
  parameter int MEM_LAT = 2
) (
  input  op_class_e        prod_i,
  input  op_class_e        cons_i,
  input  logic             data_slot_i,
  output logic [AGE_W-1:0] lat_o
);
  logic [AGE_W-1:0] nominal;
  logic             st_data;

  always_comb begin
    unique case (prod_i)
      CLS_IADD, CLS_SHIFT, CLS_ICMP: nominal = AGE_W'(2);
      CLS_IMUL32:                    nominal = AGE_W'(21);
      CLS_IMUL64:                    nominal = AGE_W'(23);
      CLS_LOAD:                      nominal = AGE_W'(MEM_LAT + 1);
      CLS_FPOP:                      nominal = AGE_W'(6);
      CLS_FDIV32:                    nominal = AGE_W'(34);
      CLS_FDIV64:                    nominal = AGE_W'(63);
      default:                       nominal = '0;
    endcase
  end

  assign st_data = data_slot_i && (cons_i == CLS_ISTORE);

  // forwarding overrides, most specific first
  always_comb begin
    lat_o = nominal;
    if (st_data && prod_i inside {CLS_IADD, CLS_SHIFT, CLS_ICMP})
      lat_o = '0;
    else if (st_data && prod_i == CLS_IMUL32)
      lat_o = AGE_W'(20);
    else if (st_data && prod_i == CLS_IMUL64)
      lat_o = AGE_W'(22);
    else if (prod_i == CLS_IADD &&
             cons_i inside {CLS_BRANCH, CLS_IADD, CLS_SHIFT, CLS_ICMP, CLS_IMUL32, CLS_IMUL64})
      lat_o = AGE_W'(1);
    else if (prod_i == CLS_ICMP && cons_i == CLS_BRANCH)
      lat_o = AGE_W'(1);
    else if (prod_i == CLS_FPOP && cons_i == CLS_FPOP)
      lat_o = AGE_W'(4);
  end
endmodule

// File: rtl/sb_src_check.sv
module sb_src_check import sb_pkg::*; #(
  parameter int AGE_W   = 6,
  parameter int MEM_LAT = 2,
  parameter bit IS_DATA = 1'b0
) (
  input  logic [AGE_W-1:0] age_i,
  input  op_class_e        prod_i,
  input  op_class_e        cons_i,
  output logic             blocked_o
);
  logic [AGE_W-1:0] lat;

  sb_lat_sel #(.AGE_W(AGE_W), .MEM_LAT(MEM_LAT)) i_lat_sel (
    .prod_i      (prod_i),
    .cons_i      (cons_i),
    .data_slot_i (IS_DATA),
    .lat_o       (lat)
  );

  assign blocked_o = age_i < lat;
endmodule

// File: rtl/sb_track.sv
module sb_track import sb_pkg::*; #(
  parameter int NUM_ENT       = 64,
  parameter int REGS_PER_FILE = 32,
  parameter int IDX_W         = 5,
  parameter int REG_W         = 6,
  parameter int AGE_W         = 6,
  parameter int NUM_SRC       = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  op_class_e                     wr_cls_i,
  input  logic [REG_W-1:0]              wr_reg_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0] rd_reg_i,
  output logic [AGE_W-1:0]              rd_age_o [NUM_SRC],
  output op_class_e                     rd_cls_o [NUM_SRC]
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  localparam logic [IDX_W-1:0] HW_IDX  = IDX_W'(REGS_PER_FILE - 1);

  logic [AGE_W-1:0] age_q [NUM_ENT];
  op_class_e        cls_q [NUM_ENT];
  logic             wr_live;

  assign wr_live = wr_en_i && (wr_reg_i[IDX_W-1:0] != HW_IDX);

  // age counts cycles since issue, saturating; hardwired entries stay saturated
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < NUM_ENT; e++) begin
        age_q[e] <= AGE_MAX;
        cls_q[e] <= CLS_MISC;
      end
    end else begin
      for (int e = 0; e < NUM_ENT; e++) begin
        if (wr_live && wr_reg_i == REG_W'(e)) begin
          age_q[e] <= AGE_W'(1);
          cls_q[e] <= wr_cls_i;
        end else if (age_q[e] != AGE_MAX) begin
          age_q[e] <= age_q[e] + AGE_W'(1);
        end
      end
    end
  end

  // same-cycle issue seen at age zero
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_rd
    logic hit;
    assign hit         = wr_live && (wr_reg_i == rd_reg_i[s]);
    assign rd_age_o[s] = hit ? '0 : age_q[rd_reg_i[s]];
    assign rd_cls_o[s] = hit ? wr_cls_i : cls_q[rd_reg_i[s]];
  end
endmodule

// File: rtl/lat_scoreboard.sv
module lat_scoreboard import sb_pkg::*; #(
  parameter  int NUM_FILES     = 2,
  parameter  int REGS_PER_FILE = 32,
  parameter  int NUM_SRC       = 2,
  parameter  int DATA_SLOT     = 1,
  parameter  int MEM_LAT       = 2,
  localparam int IDX_W         = $clog2(REGS_PER_FILE),
  localparam int REG_W         = $clog2(NUM_FILES) + IDX_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          iss_valid_i,
  input  logic [CLS_W-1:0]              iss_class_i,
  input  logic [REG_W-1:0]              iss_dst_i,
  input  logic                          cons_valid_i,
  input  logic [CLS_W-1:0]              cons_class_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0] cons_src_i,
  output logic                          stall_o
);
  localparam int NUM_ENT = NUM_FILES * REGS_PER_FILE;
  localparam int MAX_LAT = (MEM_LAT + 1 > 63) ? MEM_LAT + 1 : 63;
  localparam int AGE_W   = $clog2(MAX_LAT + 1);

  op_class_e        iss_cls;
  op_class_e        cons_cls;
  logic             wr_en;
  logic [AGE_W-1:0] src_age [NUM_SRC];
  op_class_e        src_cls [NUM_SRC];
  logic [NUM_SRC-1:0] blocked;

  assign iss_cls  = op_class_e'(iss_class_i);
  assign cons_cls = op_class_e'(cons_class_i);
  assign wr_en    = iss_valid_i && writes_result(iss_cls);

  sb_track #(
    .NUM_ENT       (NUM_ENT),
    .REGS_PER_FILE (REGS_PER_FILE),
    .IDX_W         (IDX_W),
    .REG_W         (REG_W),
    .AGE_W         (AGE_W),
    .NUM_SRC       (NUM_SRC)
  ) i_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_cls_i (iss_cls),
    .wr_reg_i (iss_dst_i),
    .rd_reg_i (cons_src_i),
    .rd_age_o (src_age),
    .rd_cls_o (src_cls)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    sb_src_check #(
      .AGE_W   (AGE_W),
      .MEM_LAT (MEM_LAT),
      .IS_DATA (s == DATA_SLOT)
    ) i_src_check (
      .age_i     (src_age[s]),
      .prod_i    (src_cls[s]),
      .cons_i    (cons_cls),
      .blocked_o (blocked[s])
    );
  end

  assign stall_o = cons_valid_i && (|blocked);
endmodule

// File: rtl/lat_scoreboard_chk.sv
module lat_scoreboard_chk import sb_pkg::*; #(
  parameter int REG_W     = 6,
  parameter int IDX_W     = 5,
  parameter int NUM_SRC   = 2,
  parameter int DATA_SLOT = 1
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          iss_valid_i,
  input logic [CLS_W-1:0]              iss_class_i,
  input logic [REG_W-1:0]              iss_dst_i,
  input logic                          cons_valid_i,
  input logic [CLS_W-1:0]              cons_class_i,
  input logic [NUM_SRC-1:0][REG_W-1:0] cons_src_i,
  input logic                          stall_o
);
  localparam logic [IDX_W-1:0] HW = '1;

  logic all_hw, rest_hw, nondata_hw, iss_wr, iss_live;

  always_comb begin
    all_hw = 1'b1;
    rest_hw = 1'b1;
    nondata_hw = 1'b1;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (cons_src_i[s][IDX_W-1:0] != HW) begin
        all_hw = 1'b0;
        if (s != 0) rest_hw = 1'b0;
        if (s != DATA_SLOT) nondata_hw = 1'b0;
      end
    end
  end

  assign iss_wr   = iss_valid_i && (iss_class_i <= 4'd8);
  assign iss_live = iss_wr && (iss_dst_i[IDX_W-1:0] != HW);

  assert_idle_no_stall_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cons_valid_i |-> !stall_o);

  assert_hw_reg_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cons_valid_i && all_hw) |-> !stall_o);

  assert_same_cycle_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_live && cons_valid_i && cons_src_i[0] == iss_dst_i) |-> stall_o);

  assert_div_pending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(iss_valid_i && iss_class_i == CLS_FDIV64 && iss_dst_i[IDX_W-1:0] != HW) &&
     cons_valid_i && cons_src_i[0] == $past(iss_dst_i)) |-> stall_o);

  assert_add_forward_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(iss_valid_i && iss_class_i == CLS_IADD && iss_dst_i[IDX_W-1:0] != HW) &&
     cons_valid_i && cons_class_i == CLS_IADD && cons_src_i[0] == $past(iss_dst_i) &&
     rest_hw && !(iss_wr && iss_dst_i == cons_src_i[0])) |-> !stall_o);

  assert_store_data_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cons_valid_i && cons_class_i == CLS_ISTORE && nondata_hw && iss_valid_i &&
     iss_class_i <= 4'd2 && iss_dst_i == cons_src_i[DATA_SLOT]) |-> !stall_o);
endmodule

bind lat_scoreboard lat_scoreboard_chk #(
  .REG_W     (REG_W),
  .IDX_W     (IDX_W),
  .NUM_SRC   (NUM_SRC),
  .DATA_SLOT (DATA_SLOT)
) i_lat_scoreboard_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .iss_valid_i  (iss_valid_i),
  .iss_class_i  (iss_class_i),
  .iss_dst_i    (iss_dst_i),
  .cons_valid_i (cons_valid_i),
  .cons_class_i (cons_class_i),
  .cons_src_i   (cons_src_i),
  .stall_o      (stall_o)
);

// File: tb/test_lat_scoreboard.sv
`timescale 1ns/1ps
module test_lat_scoreboard;
  localparam int MEM_LAT = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           iv = 1'b0;
  logic [3:0]     ic = '0;
  logic [5:0]     id = '0;
  logic           cv = 1'b0;
  logic [3:0]     cc = '0;
  logic [1:0][5:0] src = '0;
  logic           stall;

  int born [64];
  int pcl  [64];
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lat_scoreboard i_lat_scoreboard (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .iss_valid_i  (iss_v()),
    .iss_class_i  (ic),
    .iss_dst_i    (id),
    .cons_valid_i (cv),
    .cons_class_i (cc),
    .cons_src_i   (src),
    .stall_o      (stall)
  );

  function automatic logic iss_v();
    return iv;
  endfunction

  // pair latency from the requirements
  function automatic int exp_lat(int p, int c, bit data_slot);
    if (data_slot && c == 10) begin
      if (p <= 2) return 0;       // R5
      if (p == 3) return 20;      // R6
      if (p == 4) return 22;
    end
    if (p == 0 && (c == 9 || c <= 4)) return 1;   // R3
    if (p == 2 && c == 9) return 1;               // R4
    if (p == 6 && c == 6) return 4;               // R7
    case (p)
      0, 1, 2: return 2;
      3:       return 21;
      4:       return 23;
      5:       return 1 + MEM_LAT;
      6:       return 6;
      7:       return 34;
      8:       return 63;
      default: return 0;
    endcase
  endfunction

  function automatic bit src_wait(logic [5:0] r, int slot);
    int age, p;
    if (r[4:0] == 5'd31) return 1'b0;
    if (iv && ic <= 4'd8 && id == r) begin
      age = 0;
      p = int'(ic);
    end else begin
      age = cyc - born[r];
      p = pcl[r];
    end
    return age < exp_lat(p, int'(cc), slot == 1);
  endfunction

  task automatic step(input bit v_i, input int c_i, input int d_i, input bit v_c,
                      input int c_c, input int sa, input int sb, input string tag);
    bit exp;
    @(negedge clk);
    iv = v_i; ic = 4'(c_i); id = 6'(d_i);
    cv = v_c; cc = 4'(c_c); src[0] = 6'(sa); src[1] = 6'(sb);
    #1;
    exp = v_c && (src_wait(src[0], 0) || src_wait(src[1], 1));
    n_chk++;
    if (stall !== exp) begin
      n_bad++;
      $display("FAIL %s: cycle %0d stall_o=%b expected %b", tag, cyc, stall, exp);
    end
    if (v_i && c_i <= 8 && (d_i % 32) != 31) begin
      born[d_i] = cyc;
      pcl[d_i] = c_i;
    end
    cyc++;
  endtask

  task automatic sweep(input int p, input int c, input int slot, input int d, input string tag);
    int l;
    l = exp_lat(p, c, slot == 1);
    for (int k = 0; k <= l + 2; k++)
      step(k == 0, p, d, 1'b1, c, (slot == 0) ? d : 31, (slot == 1) ? d : 31, tag);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: cycle %0d reached limit, expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < 64; r++) begin
      born[r] = -100000;
      pcl[r] = 12;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: nothing pending after reset
    for (int r = 0; r < 64; r++) step(1'b0, 0, 0, 1'b1, 12, r, 63 - r, "R1");

    // R2: nominal latency of every producer class
    for (int p = 0; p <= 8; p++) sweep(p, 12, 0, (p >= 6) ? 40 + p : 3 + p, "R2");

    // R3: add/logic short path
    sweep(0, 9, 0, 5, "R3");
    for (int c = 0; c <= 4; c++) sweep(0, c, 0, 6, "R3");
    sweep(0, 6, 0, 6, "R3");

    // R4: compare to branch, and to others
    sweep(2, 9, 0, 7, "R4");
    sweep(2, 0, 0, 7, "R4");

    // R5: zero-cycle store data
    for (int p = 0; p <= 2; p++) sweep(p, 10, 1, 8, "R5");

    // R6: multiply into store data
    sweep(3, 10, 1, 9, "R6");
    sweep(4, 10, 1, 9, "R6");

    // R7: fp op chaining vs fp store
    sweep(6, 6, 0, 44, "R7");
    sweep(6, 11, 0, 44, "R7");

    // R8: store address takes nominal latency
    sweep(0, 10, 0, 10, "R8");
    sweep(3, 10, 0, 10, "R8");

    // R9: hardwired index 31
    step(1'b1, 8, 31, 1'b1, 12, 31, 63, "R9");
    step(1'b1, 8, 63, 1'b1, 12, 63, 31, "R9");
    step(1'b0, 0, 0, 1'b1, 12, 31, 63, "R9");
    step(1'b0, 0, 0, 1'b1, 10, 63, 31, "R9");

    // R10: non-writing classes leave the entry alone
    step(1'b1, 0, 11, 1'b0, 12, 31, 31, "R10");
    step(1'b0, 0, 0, 1'b0, 12, 31, 31, "R10");
    step(1'b0, 0, 0, 1'b0, 12, 31, 31, "R10");
    for (int c = 9; c <= 12; c++) step(1'b1, c, 11, 1'b1, 12, 11, 31, "R10");
    step(1'b1, 4, 12, 1'b1, 12, 12, 31, "R10");
    for (int c = 9; c <= 12; c++) step(1'b1, c, 12, 1'b1, 12, 12, 31, "R10");

    // R11: newer producer replaces older
    step(1'b1, 8, 13, 1'b1, 12, 13, 31, "R11");
    step(1'b0, 0, 0, 1'b1, 12, 13, 31, "R11");
    step(1'b1, 0, 13, 1'b1, 12, 13, 31, "R11");
    for (int k = 0; k < 4; k++) step(1'b0, 0, 0, 1'b1, 12, 13, 31, "R11");

    // R12: idle consumer never stalls, then random mix
    step(1'b1, 8, 14, 1'b0, 12, 14, 14, "R12");
    step(1'b0, 0, 0, 1'b0, 12, 14, 14, "R12");
    for (int n = 0; n < 3000; n++) begin
      int d, a, b;
      d = int'($urandom_range(1, 0)) * 32 + int'($urandom_range(31, 27));
      a = int'($urandom_range(1, 0)) * 32 + int'($urandom_range(31, 27));
      b = int'($urandom_range(1, 0)) * 32 + int'($urandom_range(31, 27));
      step(($urandom_range(2, 0) != 0), int'($urandom_range(12, 0)), d,
           ($urandom_range(3, 0) != 0), int'($urandom_range(12, 0)), a, b, "R12");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule